// File: doc/BRIEF.md
# Interrupt Indication Register Pair

This block lets a host learn about pending interrupts through two read-only words. One word is the indication word and the other is the parameter word. Interrupts come from two sources. The first is an application event queue, which supplies a code and a 16-bit parameter and is popped with a one-cycle strobe. The second is a system status vector with a mask, where any change of an unmasked bit counts as a system interrupt.

A read of the indication word reports one pending interrupt and consumes it. In the same clock edge it latches that interrupt's parameter into the parameter word. The parameter word sits at the next address, so a host that reads two words with an incrementing address receives the report and then its parameter. A read of the parameter word changes nothing.

The host bus is a plain address, read strobe and data port. Read data is registered and appears one cycle after the strobe. It holds its value while no read is issued.

Top module: `irq_report_top`

## Requirements
- R1: After reset, and after the first clock edge out of reset, `rd_data` and the parameter word are 0x0000 and `irq` is low. The status value present when reset ends is taken as the baseline and is never reported as a transition.
- R2: A read of address 0 while nothing is pending returns 0x0000. It does not pop the event queue and leaves the parameter word unchanged.
- R3: A transition is a rise or a fall of a status bit whose mask bit is 1. Each transition sets a flag at the same bit position. A change on a masked bit sets nothing. A flag that is set but currently masked is not reported and is not cleared.
- R4: Flags accumulate until they are reported. An address-0 read that reports system interrupts returns bit 15 = 1 with bits 14:0 equal to the unmasked set flags, then clears exactly those flags. A transition arriving in the same cycle as that read stays pending.
- R5: When a system interrupt is reported, the parameter word becomes {1'b0, status} as sampled on the cycle of the read.
- R6: When unmasked flags are pending, an address-0 read reports them and leaves the queue alone. Otherwise, if `evq_valid` is high, the read returns bit 15 = 0 with bits 14:0 equal to `evq_code`, loads `evq_param` into the parameter word, and raises `evq_pop` for that one cycle.
- R7: A read of address 1 returns the parameter word and changes no interrupt state and no parameter.
- R8: An address-0 read followed on the next cycle by an address-1 read returns the indication and then the matching parameter.
- R9: A read of any address other than 0 or 1 returns 0x0000 and has no side effect.
- R10: `irq` is high whenever an unmasked flag is set or `evq_valid` is high, and is low otherwise.
- R11: `rd_data` changes only on a clock edge where `rd_en` was high. It holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe, one word per cycle |
| rd_addr | input | 8 | Word address of the read |
| rd_data | output | 16 | Registered read data, valid the cycle after the strobe |
| irq | output | 1 | Interrupt request |
| sys_status | input | 15 | System status vector |
| sys_mask | input | 15 | Per-bit enable of transition detection and reporting |
| evq_valid | input | 1 | Event queue holds an entry |
| evq_code | input | 15 | Indication code of the head entry |
| evq_param | input | 16 | Parameter of the head entry |
| evq_pop | output | 1 | Consumes the head entry this cycle |

## Verification
The bench builds the block with its default parameters: a 16-bit word, an 8-bit address and the indication word at address 0. This gives fifteen flag positions. The stimulus toggles low, middle and high status bits, including bits 0, 8 and 11, in both directions. It changes masks while flags are pending, and it places a system transition on the same cycle as the read that reports an earlier one. These defaults also bring a stray address and a reset in mid-run into reach, with pending flags that must vanish.

// File: rtl/irq_report_pkg.sv
package irq_report_pkg;

    // Source flag carried in the top bit of the indication word
    typedef enum logic {
        SRC_EVENT  = 1'b0,
        SRC_SYSTEM = 1'b1
    } irq_src_e;

endpackage

// File: rtl/sys_edge_flags.sv
module sys_edge_flags #(
    parameter int unsigned W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] status,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] clr,
    output logic [W-1:0] pend
);

    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] flags;
        logic         primed;
    } trk_t;

    trk_t st_d, st_q;
    logic [W-1:0] chg;

    always_comb begin
        st_d        = st_q;
        chg         = st_q.primed ? ((status ^ st_q.prev) & mask) : '0;
        st_d.flags  = (st_q.flags & ~clr) | chg;
        st_d.prev   = status;
        st_d.primed = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.flags & mask;

    // Only flags currently visible may be cleared by a report
    assert_clear_reported_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr & ~pend) == '0);

    // A flag, once set, survives until a report clears it
    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.primed |=> ((($past(st_q.flags) & ~$past(clr)) & ~st_q.flags) == '0));

endmodule

// File: rtl/irq_source_select.sv
module irq_source_select
    import irq_report_pkg::*;
#(
    parameter int unsigned WORD_W = 16,
    localparam int unsigned SYS_W = WORD_W - 1
) (
    input  logic              rd_ind,
    input  logic [SYS_W-1:0]  pend,
    input  logic [SYS_W-1:0]  status,
    input  logic              evq_valid,
    input  logic [SYS_W-1:0]  evq_code,
    input  logic [WORD_W-1:0] evq_param,
    output logic [WORD_W-1:0] ind_word,
    output logic [WORD_W-1:0] prm_word,
    output logic              load_prm,
    output logic [SYS_W-1:0]  clr,
    output logic              pop
);

    logic sys_hit;

    always_comb begin
        sys_hit  = |pend;
        ind_word = '0;
        prm_word = '0;
        load_prm = 1'b0;
        clr      = '0;
        pop      = 1'b0;
        if (sys_hit) begin
            ind_word = {SRC_SYSTEM, pend};
            prm_word = {1'b0, status};
            load_prm = rd_ind;
            clr      = rd_ind ? pend : '0;
        end else if (evq_valid) begin
            ind_word = {SRC_EVENT, evq_code};
            prm_word = evq_param;
            load_prm = rd_ind;
            pop      = rd_ind;
        end
    end

endmodule

// File: rtl/rd_port_regs.sv
module rd_port_regs #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned ADDR_W = 8,
    parameter logic [ADDR_W-1:0] IND_ADDR = '0,
    localparam logic [ADDR_W-1:0] PRM_ADDR = ADDR_W'(IND_ADDR + 1'b1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] ind_word,
    input  logic [WORD_W-1:0] prm_word,
    input  logic              load_prm,
    output logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-1:0] prm_out
);

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [WORD_W-1:0] prm;
    } port_t;

    port_t pt_d, pt_q;

    always_comb begin
        pt_d = pt_q;
        if (rd_en) begin
            if (rd_addr == IND_ADDR) begin
                pt_d.data = ind_word;
            end else if (rd_addr == PRM_ADDR) begin
                pt_d.data = pt_q.prm;
            end else begin
                pt_d.data = '0;
            end
        end
        if (load_prm) begin
            pt_d.prm = prm_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pt_q <= '0;
        end else begin
            pt_q <= pt_d;
        end
    end

    assign rd_data = pt_q.data;
    assign prm_out = pt_q.prm;

    assert_param_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_prm |=> $stable(pt_q.prm));

    assert_data_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(pt_q.data));

endmodule

// File: rtl/irq_report_top.sv
module irq_report_top #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned ADDR_W = 8,
    parameter logic [ADDR_W-1:0] IND_ADDR = '0,
    localparam int unsigned SYS_W = WORD_W - 1,
    localparam logic [ADDR_W-1:0] PRM_ADDR = ADDR_W'(IND_ADDR + 1'b1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              irq,
    input  logic [SYS_W-1:0]  sys_status,
    input  logic [SYS_W-1:0]  sys_mask,
    input  logic              evq_valid,
    input  logic [SYS_W-1:0]  evq_code,
    input  logic [WORD_W-1:0] evq_param,
    output logic              evq_pop
);

    logic              rd_ind;
    logic [SYS_W-1:0]  pend;
    logic [SYS_W-1:0]  clr;
    logic [WORD_W-1:0] ind_word;
    logic [WORD_W-1:0] prm_word;
    logic [WORD_W-1:0] prm_q;
    logic              load_prm;

    assign rd_ind = rd_en && (rd_addr == IND_ADDR);

    sys_edge_flags #(.W(SYS_W)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .status (sys_status),
        .mask   (sys_mask),
        .clr    (clr),
        .pend   (pend)
    );

    irq_source_select #(.WORD_W(WORD_W)) u_sel (
        .rd_ind    (rd_ind),
        .pend      (pend),
        .status    (sys_status),
        .evq_valid (evq_valid),
        .evq_code  (evq_code),
        .evq_param (evq_param),
        .ind_word  (ind_word),
        .prm_word  (prm_word),
        .load_prm  (load_prm),
        .clr       (clr),
        .pop       (evq_pop)
    );

    rd_port_regs #(
        .WORD_W   (WORD_W),
        .ADDR_W   (ADDR_W),
        .IND_ADDR (IND_ADDR)
    ) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .ind_word (ind_word),
        .prm_word (prm_word),
        .load_prm (load_prm),
        .rd_data  (rd_data),
        .prm_out  (prm_q)
    );

    assign irq = (|pend) || evq_valid;

    assert_pop_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        evq_pop |-> (rd_en && rd_addr == IND_ADDR && evq_valid));

    assert_sys_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ind && (|pend)) |-> !evq_pop);

    assert_sys_snapshot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ind && (|pend)) |=> (prm_q == {1'b0, $past(sys_status)} && rd_data[WORD_W-1]));

    assert_empty_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ind && !irq) |=> (rd_data == '0 && $stable(prm_q)));

    assert_stray_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr != IND_ADDR && rd_addr != PRM_ADDR) |=> rd_data == '0);

    assert_irq_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
        evq_valid |-> irq);

endmodule

// File: tb/sim_irq_report_top.sv
`timescale 1ns/1ps
module sim_irq_report_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        irq;
    logic [14:0] sys_status = '0;
    logic [14:0] sys_mask = 15'h7FFF;
    logic        evq_valid = 1'b0;
    logic [14:0] evq_code = '0;
    logic [15:0] evq_param = '0;
    logic        evq_pop;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_report_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .irq       (irq),
        .sys_status(sys_status),
        .sys_mask  (sys_mask),
        .evq_valid (evq_valid),
        .evq_code  (evq_code),
        .evq_param (evq_param),
        .evq_pop   (evq_pop)
    );

    typedef struct packed {
        logic [14:0] st;
        logic [14:0] mk;
        logic        ev;
        logic [14:0] code;
        logic [15:0] prm;
        logic        en;
        logic [7:0]  addr;
        logic [15:0] data;
        logic        xirq;
        logic        xpop;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t TBL [NV] = '{
        '{15'h0000, 15'h7FFF, 1'b0, 15'h0000, 16'h0000, 1'b1, 8'd0, 16'h0000, 1'b0, 1'b0, 4'd2},  // R2 empty
        '{15'h0005, 15'h7FFF, 1'b0, 15'h0000, 16'h0000, 1'b0, 8'd0, 16'h0000, 1'b0, 1'b0, 4'd11}, // R11 hold
        '{15'h0005, 15'h7FFF, 1'b0, 15'h0000, 16'h0000, 1'b1, 8'd0, 16'h8005, 1'b1, 1'b0, 4'd3},  // R3 rises
        '{15'h0005, 15'h7FFF, 1'b0, 15'h0000, 16'h0000, 1'b1, 8'd1, 16'h0005, 1'b0, 1'b0, 4'd8},  // R8 pair
        '{15'h0004, 15'h7FFE, 1'b0, 15'h0000, 16'h0000, 1'b0, 8'd0, 16'h0005, 1'b0, 1'b0, 4'd3},  // R3 masked fall
        '{15'h0004, 15'h7FFF, 1'b0, 15'h0000, 16'h0000, 1'b1, 8'd0, 16'h0000, 1'b0, 1'b0, 4'd3},  // R3 nothing set
        '{15'h0004, 15'h7FFF, 1'b0, 15'h0000, 16'h0000, 1'b1, 8'd1, 16'h0005, 1'b0, 1'b0, 4'd2},  // R2 param kept
        '{15'h0004, 15'h7FFF, 1'b1, 15'h0123, 16'hBEEF, 1'b0, 8'd0, 16'h0005, 1'b1, 1'b0, 4'd10}, // R10 queue
        '{15'h0104, 15'h7FFF, 1'b1, 15'h0123, 16'hBEEF, 1'b0, 8'd0, 16'h0005, 1'b1, 1'b0, 4'd10}, // R10
        '{15'h0104, 15'h7FFF, 1'b1, 15'h0123, 16'hBEEF, 1'b1, 8'd0, 16'h8100, 1'b1, 1'b0, 4'd6},  // R6 sys first
        '{15'h0104, 15'h7FFF, 1'b1, 15'h0123, 16'hBEEF, 1'b1, 8'd0, 16'h0123, 1'b1, 1'b1, 4'd6},  // R6 event
        '{15'h0104, 15'h7FFF, 1'b0, 15'h0000, 16'h0000, 1'b1, 8'd1, 16'hBEEF, 1'b0, 1'b0, 4'd6},  // R6 param
        '{15'h0106, 15'h7FFF, 1'b0, 15'h0000, 16'h0000, 1'b1, 8'd5, 16'h0000, 1'b0, 1'b0, 4'd9},  // R9 stray
        '{15'h0106, 15'h7FFF, 1'b0, 15'h0000, 16'h0000, 1'b1, 8'd1, 16'hBEEF, 1'b1, 1'b0, 4'd9},  // R9 no effect
        '{15'h0107, 15'h7FFF, 1'b0, 15'h0000, 16'h0000, 1'b1, 8'd0, 16'h8002, 1'b1, 1'b0, 4'd4},  // R4 same-cycle
        '{15'h0107, 15'h7FFF, 1'b0, 15'h0000, 16'h0000, 1'b1, 8'd0, 16'h8001, 1'b1, 1'b0, 4'd4},  // R4 kept
        '{15'h0107, 15'h7FFF, 1'b0, 15'h0000, 16'h0000, 1'b1, 8'd1, 16'h0107, 1'b0, 1'b0, 4'd5},  // R5 snapshot
        '{15'h0007, 15'h7FFF, 1'b0, 15'h0000, 16'h0000, 1'b0, 8'd0, 16'h0107, 1'b0, 1'b0, 4'd3},  // R3 fall
        '{15'h0807, 15'h7FFF, 1'b0, 15'h0000, 16'h0000, 1'b0, 8'd0, 16'h0107, 1'b1, 1'b0, 4'd4},  // R4 accumulate
        '{15'h0807, 15'h7FFF, 1'b0, 15'h0000, 16'h0000, 1'b1, 8'd0, 16'h8900, 1'b1, 1'b0, 4'd4},  // R4
        '{15'h0807, 15'h7FFF, 1'b0, 15'h0000, 16'h0000, 1'b1, 8'd1, 16'h0807, 1'b0, 1'b0, 4'd7}   // R7
    };

    task automatic chk(input bit ok, input int req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input vec_t v);
        @(negedge clk);
        sys_status = v.st;
        sys_mask   = v.mk;
        evq_valid  = v.ev;
        evq_code   = v.code;
        evq_param  = v.prm;
        rd_en      = v.en;
        rd_addr    = v.addr;
        #1;
        chk(irq == v.xirq, int'(v.req), "irq", {15'd0, irq}, {15'd0, v.xirq});
        chk(evq_pop == v.xpop, int'(v.req), "pop", {15'd0, evq_pop}, {15'd0, v.xpop});
        @(posedge clk);
        #1;
        chk(rd_data == v.data, int'(v.req), "rd_data", rd_data, v.data);
    endtask

    function automatic vec_t mk_vec(input logic [14:0] st, input logic [14:0] mk,
                                    input logic en, input logic [7:0] addr,
                                    input logic [15:0] data, input logic xirq,
                                    input logic [3:0] req);
        vec_t v;
        v = '{st, mk, 1'b0, 15'h0, 16'h0, en, addr, data, xirq, 1'b0, req};
        return v;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(rd_data == 16'h0000, 1, "rd_data at reset", rd_data, 16'h0000);
        chk(irq == 1'b0, 1, "irq at reset", {15'd0, irq}, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(TBL[i]);
        end

        // R3 masked pending flag is neither reported nor lost
        step(mk_vec(15'h080F, 15'h7FFF, 1'b0, 8'd0, 16'h0807, 1'b0, 4'd3));
        step(mk_vec(15'h080F, 15'h7FF7, 1'b0, 8'd0, 16'h0807, 1'b0, 4'd10));
        step(mk_vec(15'h080F, 15'h7FF7, 1'b1, 8'd0, 16'h0000, 1'b0, 4'd3));
        step(mk_vec(15'h080F, 15'h7FFF, 1'b1, 8'd0, 16'h8008, 1'b1, 4'd3));

        // R1 reset in mid-run drops a pending flag and the parameter
        step(mk_vec(15'h000F, 15'h7FFF, 1'b0, 8'd0, 16'h8008, 1'b0, 4'd1));
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk(rd_data == 16'h0000, 1, "rd_data after reset", rd_data, 16'h0000);
        chk(irq == 1'b0, 1, "irq after reset", {15'd0, irq}, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 baseline taken on the first edge: no transition reported
        step(mk_vec(15'h000F, 15'h7FFF, 1'b1, 8'd0, 16'h0000, 1'b0, 4'd1));
        step(mk_vec(15'h000F, 15'h7FFF, 1'b1, 8'd1, 16'h0000, 1'b0, 4'd1));

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule